// File: doc/BRIEF.md
# Radio Operating-Mode Sequencer

This block drives a narrowband transceiver through its operating modes. A host issues a mode command (power up, power down, enter transmit, enter receive, or one of the two quick turnarounds between transmit and receive). The sequencer drives the radio's chip-enable pin. It then plays a fixed script of 32-bit configuration words into a serial master, one word per request/done handshake. Timed settling waits sit between particular words. When the script ends, the sequencer reports the new operating mode.

The length of each wait comes from two parameters: the clock frequency and the air bit time. Three optional features are sampled when a command is accepted, and they add or remove script steps: a crystal start-up wait, an internal amplifier ramp, and automatic frequency correction. The controller accepts one command at a time. It rejects a command that arrives while a script is running, an unknown command, and any command other than power-up or power-down while the radio is unpowered.

Top module: `radio_mode_seq`

## Requirements
- R1: After reset, chip_en is 0, mode_state is 0 (unpowered), busy, wr_req and cmd_err are 0, and tx_ready and rx_ready are 0.
- R2: Command code 0 (power up) with chip_en low raises chip_en and ends in mode_state 1 (powered idle) with no word written. A wait of 1 ms comes before the end only when xtal_wait_en is 1 at acceptance. The same command with chip_en already high is ignored: no word, no error, no busy, and the mode is unchanged.
- R3: Command code 2 (transmit) writes 0x021B5031, waits 800 µs, writes 0x2B1525E3 and 0x81187CF0, waits 40 µs, and writes 0x0067FD82. If pa_ramp_en is 1 at acceptance, a further 4 bit times are waited. The script ends in mode_state 2 with tx_ready set.
- R4: Command code 3 (receive) writes 0x00535011, 0x2B1734E3 and 0x00003155, waits 200 µs, writes 0x091A2B3B, 0x0000018C and 0x095F2DC0, waits 40 µs, and writes 0x8016AA14. It then writes 0x3296355A only if afc_en is 1 at acceptance. The script ends in mode_state 3 with rx_ready set.
- R5: Command code 4 (transmit-to-receive) writes only 0x885D7EF0, waits 40 µs and ends in mode_state 3.
- R6: Command code 5 (receive-to-transmit) writes only 0x805D7EF0, waits 40 µs and ends in mode_state 2.
- R7: Command code 1 (power down) first writes 0x00685502 and waits 4 bit times, but only if chip_en is high and pa_ramp_en is 1 at acceptance. It then drops chip_en, sets mode_state 0 and clears tx_ready and rx_ready.
- R8: wr_req stays high with wr_word unchanged until wr_done is seen, and it falls on the cycle after wr_done. Each handshake transfers exactly one word.
- R9: Every wait lasts at least its duration times CLK_HZ/1e6 clock cycles (minimum 1 cycle per µs). A bit time is BIT_US µs.
- R10: Any command while busy is 1 produces a one-cycle cmd_err pulse and leaves the running script unaffected.
- R11: Codes 2 to 5 issued while chip_en is low, and codes 6 and 7 at any time, produce a one-cycle cmd_err pulse. They cause no write and no change of state.
- R12: busy is high from the cycle after acceptance until the script completes. wr_req is high only while busy and chip_en are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Command: 0 up, 1 down, 2 tx, 3 rx, 4 tx-to-rx, 5 rx-to-tx |
| xtal_wait_en | input | 1 | Crystal start-up wait option, sampled with the command |
| pa_ramp_en | input | 1 | Internal amplifier ramp option, sampled with the command |
| afc_en | input | 1 | Frequency-correction option, sampled with the command |
| wr_done | input | 1 | Serial master has shifted out the word |
| chip_en | output | 1 | Radio chip-enable pin |
| wr_req | output | 1 | Word ready for the serial master |
| wr_word | output | 32 | Configuration word to send |
| mode_state | output | 2 | 0 unpowered, 1 powered idle, 2 transmit, 3 receive |
| busy | output | 1 | Script in progress |
| cmd_err | output | 1 | Command rejected (one-cycle pulse) |
| tx_ready | output | 1 | Full transmit script has run since power-up |
| rx_ready | output | 1 | Full receive script has run since power-up |

## Verification
The bench builds the block with CLK_HZ = 1 MHz and BIT_US = 50. At these values one microsecond is one clock, so the 800 µs and 1 ms settling waits and the 200-cycle ramp wait can all be measured to the cycle range, and a long random command mix still fits the run. Under these values the bench drives every script with each option flag both set and clear, which covers both the inserted steps and the skipped ones. It also sends commands in the middle of a wait, so that rejection during a running script is tested.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        MS_OFF  = 2'd0,
        MS_IDLE = 2'd1,
        MS_TX   = 2'd2,
        MS_RX   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        CM_UP   = 3'd0,
        CM_DOWN = 3'd1,
        CM_TX   = 3'd2,
        CM_RX   = 3'd3,
        CM_T2R  = 3'd4,
        CM_R2T  = 3'd5,
        CM_BAD6 = 3'd6,
        CM_BAD7 = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {SK_WRITE, SK_WAIT, SK_END} step_kind_e;
    typedef enum logic [1:0] {GT_ALWAYS, GT_XTAL, GT_RAMP, GT_AFC} gate_e;
    typedef enum logic [2:0] {WT_40US, WT_200US, WT_800US, WT_1MS, WT_4BIT} wait_e;
    typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_WRITE, PH_WAIT} phase_e;

    typedef struct packed {
        step_kind_e        kind;
        gate_e             gate;
        wait_e             wsel;
        logic [WORD_W-1:0] word;
    } step_t;

    typedef struct packed {
        phase_e            phase;
        cmd_e              script;
        logic [IDX_W-1:0]  idx;
        logic              g_xtal;
        logic              g_ramp;
        logic              g_afc;
        logic              ce;
        mode_e             mode;
        logic              tx_rdy;
        logic              rx_rdy;
        logic              req;
        logic [WORD_W-1:0] word;
        logic              err;
    } ctl_t;

    function automatic step_t mk_wr(gate_e g, logic [WORD_W-1:0] w);
        step_t s;
        s.kind = SK_WRITE; s.gate = g; s.wsel = WT_40US; s.word = w;
        return s;
    endfunction

    function automatic step_t mk_wait(gate_e g, wait_e t);
        step_t s;
        s.kind = SK_WAIT; s.gate = g; s.wsel = t; s.word = '0;
        return s;
    endfunction

    function automatic step_t mk_end();
        step_t s;
        s.kind = SK_END; s.gate = GT_ALWAYS; s.wsel = WT_40US; s.word = '0;
        return s;
    endfunction

endpackage

// File: rtl/mode_script_rom.sv
module mode_script_rom
    import radio_seq_pkg::*;
(
    input  cmd_e             script,
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    always_comb begin
        step = mk_end();
        unique case (script)
            CM_UP: case (idx)
                4'd0:    step = mk_wait(GT_XTAL, WT_1MS);
                default: step = mk_end();
            endcase
            CM_DOWN: case (idx)
                4'd0:    step = mk_wr(GT_RAMP, 32'h0068_5502);
                4'd1:    step = mk_wait(GT_RAMP, WT_4BIT);
                default: step = mk_end();
            endcase
            CM_TX: case (idx)
                4'd0:    step = mk_wr(GT_ALWAYS, 32'h021B_5031);
                4'd1:    step = mk_wait(GT_ALWAYS, WT_800US);
                4'd2:    step = mk_wr(GT_ALWAYS, 32'h2B15_25E3);
                4'd3:    step = mk_wr(GT_ALWAYS, 32'h8118_7CF0);
                4'd4:    step = mk_wait(GT_ALWAYS, WT_40US);
                4'd5:    step = mk_wr(GT_ALWAYS, 32'h0067_FD82);
                4'd6:    step = mk_wait(GT_RAMP, WT_4BIT);
                default: step = mk_end();
            endcase
            CM_RX: case (idx)
                4'd0:    step = mk_wr(GT_ALWAYS, 32'h0053_5011);
                4'd1:    step = mk_wr(GT_ALWAYS, 32'h2B17_34E3);
                4'd2:    step = mk_wr(GT_ALWAYS, 32'h0000_3155);
                4'd3:    step = mk_wait(GT_ALWAYS, WT_200US);
                4'd4:    step = mk_wr(GT_ALWAYS, 32'h091A_2B3B);
                4'd5:    step = mk_wr(GT_ALWAYS, 32'h0000_018C);
                4'd6:    step = mk_wr(GT_ALWAYS, 32'h095F_2DC0);
                4'd7:    step = mk_wait(GT_ALWAYS, WT_40US);
                4'd8:    step = mk_wr(GT_ALWAYS, 32'h8016_AA14);
                4'd9:    step = mk_wr(GT_AFC, 32'h3296_355A);
                default: step = mk_end();
            endcase
            CM_T2R: case (idx)
                4'd0:    step = mk_wr(GT_ALWAYS, 32'h885D_7EF0);
                4'd1:    step = mk_wait(GT_ALWAYS, WT_40US);
                default: step = mk_end();
            endcase
            CM_R2T: case (idx)
                4'd0:    step = mk_wr(GT_ALWAYS, 32'h805D_7EF0);
                4'd1:    step = mk_wait(GT_ALWAYS, WT_40US);
                default: step = mk_end();
            endcase
            default: step = mk_end();
        endcase
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0) && !load;

    // R9: a running count only steps down by one per cycle
    assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
    import radio_seq_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int BIT_US = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              xtal_wait_en,
    input  logic              pa_ramp_en,
    input  logic              afc_en,
    input  logic              wr_done,
    output logic              chip_en,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_word,
    output logic [1:0]        mode_state,
    output logic              busy,
    output logic              cmd_err,
    output logic              tx_ready,
    output logic              rx_ready
);
    localparam int CYC_US  = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int N_40US  = 40 * CYC_US;
    localparam int N_200US = 200 * CYC_US;
    localparam int N_800US = 800 * CYC_US;
    localparam int N_1MS   = 1000 * CYC_US;
    localparam int N_4BIT  = 4 * BIT_US * CYC_US;
    localparam int N_MAX   = (N_4BIT > N_1MS) ? N_4BIT : N_1MS;
    localparam int CNT_W   = $clog2(N_MAX + 1);

    ctl_t  q, d;
    step_t step;
    logic  gate_ok, tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    cmd_e  cmd_in;

    assign cmd_in = cmd_e'(cmd_code);

    mode_script_rom u_rom (
        .script (q.script),
        .idx    (q.idx),
        .step   (step)
    );

    settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        unique case (step.gate)
            GT_XTAL: gate_ok = q.g_xtal;
            GT_RAMP: gate_ok = q.g_ramp;
            GT_AFC:  gate_ok = q.g_afc;
            default: gate_ok = 1'b1;
        endcase
    end

    always_comb begin
        d        = q;
        d.err    = 1'b0;
        tmr_load = 1'b0;
        unique case (step.wsel)
            WT_200US: tmr_val = CNT_W'(N_200US);
            WT_800US: tmr_val = CNT_W'(N_800US);
            WT_1MS:   tmr_val = CNT_W'(N_1MS);
            WT_4BIT:  tmr_val = CNT_W'(N_4BIT);
            default:  tmr_val = CNT_W'(N_40US);
        endcase

        if (q.phase != PH_IDLE && cmd_valid)
            d.err = 1'b1;

        unique case (q.phase)
            PH_IDLE: if (cmd_valid) begin
                if (cmd_in == CM_BAD6 || cmd_in == CM_BAD7) begin
                    d.err = 1'b1;
                end else if (cmd_in == CM_UP) begin
                    if (!q.ce) begin
                        d.ce     = 1'b1;
                        d.script = cmd_in;
                        d.idx    = '0;
                        d.g_xtal = xtal_wait_en;
                        d.phase  = PH_FETCH;
                    end
                end else if (cmd_in != CM_DOWN && !q.ce) begin
                    d.err = 1'b1;
                end else begin
                    d.script = cmd_in;
                    d.idx    = '0;
                    d.g_xtal = xtal_wait_en;
                    d.g_ramp = pa_ramp_en & q.ce;
                    d.g_afc  = afc_en;
                    d.phase  = PH_FETCH;
                end
            end
            PH_FETCH: begin
                unique case (step.kind)
                    SK_END: begin
                        d.phase = PH_IDLE;
                        unique case (q.script)
                            CM_UP:   d.mode = MS_IDLE;
                            CM_DOWN: begin
                                d.ce     = 1'b0;
                                d.mode   = MS_OFF;
                                d.tx_rdy = 1'b0;
                                d.rx_rdy = 1'b0;
                            end
                            CM_TX:   begin d.mode = MS_TX; d.tx_rdy = 1'b1; end
                            CM_RX:   begin d.mode = MS_RX; d.rx_rdy = 1'b1; end
                            CM_T2R:  d.mode = MS_RX;
                            CM_R2T:  d.mode = MS_TX;
                            default: d.mode = q.mode;
                        endcase
                    end
                    SK_WRITE: begin
                        if (gate_ok) begin
                            d.req   = 1'b1;
                            d.word  = step.word;
                            d.phase = PH_WRITE;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                    default: begin
                        if (gate_ok) begin
                            tmr_load = 1'b1;
                            d.phase  = PH_WAIT;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                endcase
            end
            PH_WRITE: if (wr_done) begin
                d.req   = 1'b0;
                d.idx   = q.idx + 1'b1;
                d.phase = PH_FETCH;
            end
            default: if (tmr_expired) begin
                d.idx   = q.idx + 1'b1;
                d.phase = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.phase  <= PH_IDLE;
            q.script <= CM_UP;
            q.mode   <= MS_OFF;
        end else begin
            q <= d;
        end
    end

    assign chip_en    = q.ce;
    assign wr_req     = q.req;
    assign wr_word    = q.word;
    assign mode_state = q.mode;
    assign busy       = (q.phase != PH_IDLE);
    assign cmd_err    = q.err;
    assign tx_ready   = q.tx_rdy;
    assign rx_ready   = q.rx_rdy;

    // R8: request held with a stable word until the master answers
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_word)));
    // R8: request withdrawn right after done
    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_done) |=> !wr_req);
    // R12: words only go out inside a script with the radio powered
    assert_req_in_script_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (busy && chip_en));
    // R7: an unpowered idle radio always reports mode 0
    assert_off_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !chip_en) |-> (mode_state == 2'd0));
    // R10: an error pulse always follows a command strobe
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid));
    // R10: a command during a script does not disturb the script position
    assert_busy_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && !wr_done && !tmr_expired && q.phase != PH_FETCH)
        |=> (busy && cmd_err && $stable(q.idx)));
endmodule

// File: tb/sim_radio_mode_seq.sv
`timescale 1ns/1ps
module sim_radio_mode_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        xtal_wait_en = 1'b0, pa_ramp_en = 1'b0, afc_en = 1'b0;
    logic        wr_done = 1'b0;
    logic        chip_en, wr_req, busy, cmd_err, tx_ready, rx_ready;
    logic [31:0] wr_word;
    logic [1:0]  mode_state;

    radio_mode_seq #(.CLK_HZ(1_000_000), .BIT_US(50)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .xtal_wait_en(xtal_wait_en), .pa_ramp_en(pa_ramp_en), .afc_en(afc_en),
        .wr_done(wr_done), .chip_en(chip_en), .wr_req(wr_req), .wr_word(wr_word),
        .mode_state(mode_state), .busy(busy), .cmd_err(cmd_err),
        .tx_ready(tx_ready), .rx_ready(rx_ready)
    );

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int lat = 0, lowcnt = 0, nw = 0, ngap = 0;
    bit req_seen = 0, hung = 0;
    logic [31:0] words [16];
    int gaps [16];
    logic [31:0] exp_w [16];
    int exp_pre [16];
    int ne = 0, exp_tail = 0;
    bit m_ce = 0, m_tx = 0, m_rx = 0;
    int m_mode = 0;

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_gap(string req, int g, int w);
        n_checks++;
        if (w == 0 ? (g > 4) : (g < w || g > w + 6)) begin
            n_fail++;
            $display("FAIL %s gap actual=%0d expected=%0d", req, g, w);
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // one clock: serial master model and gap monitor, all at the falling edge
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > 150000 && !hung) begin
            hung = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
        if (wr_done) begin
            wr_done = 1'b0;
        end else if (wr_req) begin
            if (!req_seen) begin
                if (ngap < 16) gaps[ngap] = lowcnt;
                ngap++;
                req_seen = 1;
            end
            if (lat == 0) begin
                wr_done = 1'b1;
                if (nw < 16) words[nw] = wr_word;
                nw++;
                lat = $urandom % 3;
                req_seen = 0;
                lowcnt = 0;
            end else begin
                lat--;
            end
        end
        if (!wr_req) lowcnt++;
    endtask

    function automatic void add_w(logic [31:0] w, int pre);
        exp_w[ne] = w; exp_pre[ne] = pre; ne++;
    endfunction

    // expected script from the requirements (1 cycle per us, bit time 50 us)
    function automatic void build_exp(int code, bit x, bit r, bit a);
        ne = 0; exp_tail = 0;
        case (code)
            0: exp_tail = x ? 1000 : 0;                                   // R2
            1: if (m_ce && r) begin add_w(32'h00685502, 0); exp_tail = 200; end // R7
            2: begin                                                      // R3
                add_w(32'h021B5031, 0); add_w(32'h2B1525E3, 800);
                add_w(32'h81187CF0, 0); add_w(32'h0067FD82, 40);
                exp_tail = r ? 200 : 0;
            end
            3: begin                                                      // R4
                add_w(32'h00535011, 0); add_w(32'h2B1734E3, 0);
                add_w(32'h00003155, 0); add_w(32'h091A2B3B, 200);
                add_w(32'h0000018C, 0); add_w(32'h095F2DC0, 0);
                add_w(32'h8016AA14, 40);
                if (a) add_w(32'h3296355A, 0);
            end
            4: begin add_w(32'h885D7EF0, 0); exp_tail = 40; end           // R5
            5: begin add_w(32'h805D7EF0, 0); exp_tail = 40; end           // R6
            default: ;
        endcase
    endfunction

    // issue one command; inject>0 sends a second command that many cycles in
    task automatic run_cmd(int code, bit x, bit r, bit a, int inject);
        bit exp_err, accepted;
        int prev_mode;
        string tag;
        exp_err  = (code >= 6) || (!m_ce && code >= 2);
        accepted = !exp_err && !(code == 0 && m_ce);
        tag = (code >= 6 || (!m_ce && code >= 2)) ? "R11" :
              (code == 0) ? "R2" : (code == 1) ? "R7" : (code == 2) ? "R3" :
              (code == 3) ? "R4" : (code == 4) ? "R5" : "R6";
        build_exp(code, x, r, a);
        prev_mode = mode_state;
        nw = 0; ngap = 0; lowcnt = 0; req_seen = 0;
        cmd_code = 3'(code); xtal_wait_en = x; pa_ramp_en = r; afc_en = a;
        cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
        check({tag, " cmd_err"}, cmd_err, exp_err);
        check("R12 busy after accept", busy, accepted);
        for (int k = 1; busy && k < 20000; k++) begin
            if (k == inject) begin
                cmd_code = 3'($urandom % 8); cmd_valid = 1'b1;
                tick();
                cmd_valid = 1'b0;
                check("R10 busy reject pulse", cmd_err, 1);
                tick();
                check("R10 pulse one cycle", cmd_err, 0);
            end else begin
                tick();
            end
        end
        if (!accepted) begin
            repeat (2) tick();
            check({tag, " no write"}, nw, 0);
            check({tag, " mode unchanged"}, mode_state, prev_mode);
            check({tag, " chip_en unchanged"}, chip_en, m_ce);
            return;
        end
        check({tag, " word count"}, nw, ne);
        for (int i = 0; i < ne && i < nw; i++) begin
            check({tag, " word"}, words[i], exp_w[i]);
            check_gap("R9 wait before word", gaps[i], exp_pre[i]);
        end
        check_gap("R9 tail wait", lowcnt, exp_tail);
        case (code)
            0: begin m_ce = 1; m_mode = 1; end
            1: begin m_ce = 0; m_mode = 0; m_tx = 0; m_rx = 0; end
            2: begin m_mode = 2; m_tx = 1; end
            3: begin m_mode = 3; m_rx = 1; end
            4: m_mode = 3;
            default: m_mode = 2;
        endcase
        check({tag, " mode"}, mode_state, m_mode);
        check({tag, " chip_en"}, chip_en, m_ce);
        check({tag, " tx_ready"}, tx_ready, m_tx);
        check({tag, " rx_ready"}, rx_ready, m_rx);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 chip_en", chip_en, 0);
        check("R1 mode", mode_state, 0);
        check("R1 busy", busy, 0);
        check("R1 wr_req", wr_req, 0);
        check("R1 cmd_err", cmd_err, 0);
        check("R1 ready flags", {tx_ready, rx_ready}, 0);

        run_cmd(2, 0, 0, 0, 0);   // R11 tx while unpowered
        run_cmd(6, 0, 0, 0, 0);   // R11 unknown code
        run_cmd(1, 0, 1, 0, 0);   // R7 down while unpowered: no close word
        run_cmd(0, 1, 0, 0, 0);   // R2 with crystal wait
        run_cmd(0, 0, 0, 0, 0);   // R2 ignored when already up
        run_cmd(7, 0, 0, 0, 0);   // R11 unknown code while up
        run_cmd(2, 0, 1, 0, 300); // R3 with ramp, R10 inject mid-wait
        run_cmd(4, 0, 0, 0, 0);   // R5
        run_cmd(5, 0, 0, 0, 0);   // R6
        run_cmd(3, 0, 0, 1, 100); // R4 with AFC, R10 inject
        run_cmd(3, 0, 0, 0, 0);   // R4 without AFC
        run_cmd(1, 0, 1, 0, 0);   // R7 with ramp close word
        run_cmd(0, 0, 0, 0, 0);   // R2 without crystal wait
        run_cmd(2, 0, 0, 0, 0);   // R3 without ramp
        run_cmd(1, 0, 0, 0, 0);   // R7 without ramp

        for (int n = 0; n < 40; n++) begin
            int c;
            c = $urandom % 8;
            if (!m_ce && ($urandom % 2)) c = 0;
            run_cmd(c, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                    ($urandom % 4 == 0) ? 30 : 0);
            repeat ($urandom % 3) tick();
        end
        finish_run();
    end
endmodule